// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches a synchronised I2C bus and decides, byte by byte during the address phase, whether the local device is the target of the transfer. It handles both 7-bit and 10-bit slave addressing. The 7-bit address and the low eight bits of a 10-bit address come from an 8-bit own-address input. The two upper bits of a 10-bit address come from a separate 2-bit input.

When the address matches, the block pulses a match flag and records the transfer direction. It answers the acknowledge slot by pulling SDA low, unless the software not-acknowledge control is set. When the address does not match, or recognition is inhibited, the block leaves SDA released and ignores the bus until the next START condition. A STOP condition ends the selection.

The block only recognises addresses. Moving data after a match is left to the logic around it.

Top module: `i2c_addr_match`

## Requirements
- R1: In 7-bit mode (`ten_bit_i`=0), a first byte after START whose bits [7:1] equal `own_addr_i[6:0]` is a match. The block acknowledges it by pulling SDA low during the 9th SCL high phase, pulses `sam_o` for one clock, raises `addressed_o` and sets `rw_o` to bit 0 of the byte (1 = read).
- R2: After a first byte that does not match, SDA stays released and `addressed_o` stays 0. Every later byte is ignored, even one carrying a matching address, until the next START.
- R3: When `inhibit_i`=1 at the end of an address byte, no match is declared and no acknowledge is given.
- R4: In 10-bit mode, a first byte of the form 11110, then `addr_hi_i[1:0]`, then write (0) is acknowledged without pulsing `sam_o`. A first byte with a different prefix or different upper bits is not acknowledged.
- R5: In 10-bit mode, a second byte equal to `own_addr_i[7:0]` after an acknowledged header completes the match. The block acknowledges it, pulses `sam_o`, raises `addressed_o` and sets `rw_o`=0.
- R6: In 10-bit mode, a second byte that differs from `own_addr_i[7:0]` is not acknowledged and leaves `addressed_o` at 0.
- R7: After a completed 10-bit match and without an intervening STOP, a repeated START followed by the header with read (1) selects the device again. The block acknowledges, pulses `sam_o` and sets `rw_o`=1, with no second byte needed.
- R8: A 10-bit read header that follows a STOP, with no completed 10-bit match since that STOP, is not acknowledged.
- R9: With `nak_i`=1, a matching address still pulses `sam_o` and sets `addressed_o`, but SDA stays released in the acknowledge slot.
- R10: A STOP (SDA rising while SCL is high) clears `addressed_o` on the next clock.
- R11: After reset, `sda_pull_o`, `sam_o`, `addressed_o` and `rw_o` are all 0.
- R12: `sda_pull_o` changes only on an SCL falling edge or a START. It is released on the SCL fall that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| inhibit_i | input | 1 | 1 disables address recognition |
| nak_i | input | 1 | 1 answers a matching address with not-acknowledge |
| own_addr_i | input | 8 | 7-bit address in [6:0]; low 8 bits of the 10-bit address |
| addr_hi_i | input | 2 | Upper two bits of the 10-bit address |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| sam_o | output | 1 | One-clock pulse when a full address match is declared |
| addressed_o | output | 1 | Device is currently selected |
| rw_o | output | 1 | Direction of the selected transfer, 1 = read |

## Verification
The bench targets the two-byte 10-bit path. A design that declared the match on the header alone would pulse the flag too early. A design that skipped the low-byte comparison would acknowledge a foreign second byte. It also checks the read re-selection across a repeated START and its rejection after a STOP; a design that kept or dropped the 10-bit selection at the wrong time would acknowledge in the wrong one of these two cases. Further cases are a matching byte sent after a mismatch, which a design that resumed listening early would acknowledge, and the not-acknowledge and inhibit controls, which a careless design would ignore or tie to the match flag. After every acknowledge slot the bench checks that SDA has been released, which catches a pull-down held past its slot.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int AM_BYTE_W = 8;
  localparam int AM_HI_W   = 2;
  localparam logic [4:0] AM_TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    AM_IDLE, AM_HDR, AM_LOW, AM_SEL, AM_SKIP
  } am_state_e;

  // 7-bit hit: upper seven bits of the byte carry the address
  function automatic logic am_hit7(input logic [7:0] b, input logic [6:0] a);
    return b[7:1] == a;
  endfunction

  // 10-bit header hit: prefix and the two upper address bits
  function automatic logic am_hit10_hdr(input logic [7:0] b, input logic [1:0] hi);
    return (b[7:3] == AM_TEN_PREFIX) && (b[2:1] == hi);
  endfunction

  function automatic logic am_hit10_low(input logic [7:0] b, input logic [7:0] lo);
    return b == lo;
  endfunction
endpackage

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_rise_i,
  input  logic            start_i,
  input  logic            sda_i,
  output logic [BITS-1:0] byte_o,
  output logic            byte_done_o
);
  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] ACKC = CNT_W'(BITS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      byte_o      <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= '0;
      end else if (scl_rise_i) begin
        if (cnt_q == ACKC) begin
          cnt_q <= '0;
        end else begin
          byte_o      <= {byte_o[BITS-2:0], sda_i};
          cnt_q       <= cnt_q + 1'b1;
          byte_done_o <= (cnt_q == LAST);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_am_ack.sv
module i2c_am_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic scl_fall_i,
  input  logic start_i,
  output logic pull_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pull_o  <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b0;
      pull_o  <= 1'b0;
    end else begin
      if (arm_i) armed_q <= 1'b1;
      if (scl_fall_i) begin
        pull_o  <= armed_q;
        armed_q <= 1'b0;
      end
    end
  end

  // R12
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall_i && !start_i) |=> $stable(pull_o));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ten_bit_i,
  input  logic       inhibit_i,
  input  logic       nak_i,
  input  logic [7:0] own_addr_i,
  input  logic [1:0] addr_hi_i,
  output logic       sda_pull_o,
  output logic       sam_o,
  output logic       addressed_o,
  output logic       rw_o
);
  import i2c_am_pkg::*;

  logic scl_rise_w, scl_fall_w, start_w, stop_w;
  logic [AM_BYTE_W-1:0] byte_w;
  logic byte_done_w;
  logic arm_w;

  am_state_e st_q, st_n;
  logic ten_sel_q, ten_sel_n, rw_n, sam_n;

  i2c_am_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
    .start_o(start_w), .stop_o(stop_w)
  );

  i2c_am_shift #(.BITS(AM_BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise_w), .start_i(start_w),
    .sda_i(sda_i), .byte_o(byte_w), .byte_done_o(byte_done_w)
  );

  i2c_am_ack u_ack (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_w), .scl_fall_i(scl_fall_w),
    .start_i(start_w), .pull_o(sda_pull_o)
  );

  always_comb begin
    st_n      = st_q;
    ten_sel_n = ten_sel_q;
    rw_n      = rw_o;
    sam_n     = 1'b0;
    arm_w     = 1'b0;
    if (stop_w) begin
      st_n      = AM_IDLE;
      ten_sel_n = 1'b0;
    end else if (start_w) begin
      st_n = AM_HDR;
    end else if (byte_done_w) begin
      unique case (st_q)
        AM_HDR: begin
          st_n = AM_SKIP;
          if (!inhibit_i) begin
            if (!ten_bit_i) begin
              if (am_hit7(byte_w, own_addr_i[6:0])) begin
                st_n = AM_SEL; sam_n = 1'b1; rw_n = byte_w[0]; arm_w = !nak_i;
              end
            end else if (am_hit10_hdr(byte_w, addr_hi_i)) begin
              if (!byte_w[0]) begin
                st_n = AM_LOW; arm_w = !nak_i;
              end else if (ten_sel_q) begin
                st_n = AM_SEL; sam_n = 1'b1; rw_n = 1'b1; arm_w = !nak_i;
              end
            end
          end
        end
        AM_LOW: begin
          if (!inhibit_i && am_hit10_low(byte_w, own_addr_i)) begin
            st_n = AM_SEL; sam_n = 1'b1; rw_n = 1'b0; ten_sel_n = 1'b1; arm_w = !nak_i;
          end else begin
            st_n = AM_SKIP; ten_sel_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= AM_IDLE;
      ten_sel_q <= 1'b0;
      rw_o      <= 1'b0;
      sam_o     <= 1'b0;
    end else begin
      st_q      <= st_n;
      ten_sel_q <= ten_sel_n;
      rw_o      <= rw_n;
      sam_o     <= sam_n;
    end
  end

  assign addressed_o = (st_q == AM_SEL);

  // R5
  sam_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sam_o |-> $past(byte_done_w));
  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> !addressed_o);
  // R3
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_w && st_q == AM_HDR && inhibit_i && !start_w && !stop_w)
      |=> (!sam_o && !addressed_o));
  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == AM_SKIP) |-> !sda_pull_o);
endmodule

// File: tb/i2c_addr_match_tb_top.sv
module i2c_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic ten_bit = 1'b0, inhibit = 1'b0, nak = 1'b0;
  logic [7:0] own_addr = 8'h5A;
  logic [1:0] addr_hi = 2'b10;
  logic sda_pull, sam, addressed, rw;
  logic sda_bus;
  int checks = 0, errors = 0, sam_cnt = 0;
  bit exp_q[$];
  string tag_q[$];
  event ack_ev;

  always #5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  i2c_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .ten_bit_i(ten_bit), .inhibit_i(inhibit), .nak_i(nak),
    .own_addr_i(own_addr), .addr_hi_i(addr_hi),
    .sda_pull_o(sda_pull), .sam_o(sam), .addressed_o(addressed), .rw_o(rw)
  );

  always @(negedge clk) if (rst_n && sam) sam_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares the bus level in each acknowledge slot
  initial forever begin
    @(ack_ev);
    #1;
    if (exp_q.size() > 0) chk(tag_q.pop_front(), (sda_bus == 1'b0), exp_q.pop_front());
  end

  task automatic qd(); repeat (3) @(negedge clk); endtask

  task automatic do_start();
    m_sda = 1'b1; qd(); m_scl = 1'b1; qd(); m_sda = 1'b0; qd(); m_scl = 1'b0; qd();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; qd(); m_scl = 1'b1; qd(); m_sda = 1'b1; qd();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    exp_q.push_back(exp_ack);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qd(); m_scl = 1'b1; qd(); m_scl = 1'b0; qd();
    end
    m_sda = 1'b1; qd(); m_scl = 1'b1; qd();
    -> ack_ev;
    qd(); m_scl = 1'b0; qd();
    chk("R12 released after slot", sda_pull, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 sda_pull", sda_pull, 0);
    chk("R11 sam", sam, 0);
    chk("R11 addressed", addressed, 0);
    chk("R11 rw", rw, 0);
    rst_n = 1'b1;
    qd();

    // R1 7-bit read match
    s0 = sam_cnt;
    do_start(); send_byte(8'hB5, 1, "R1 ack");
    chk("R1 addressed", addressed, 1);
    chk("R1 rw", rw, 1);
    chk("R1 sam", sam_cnt - s0, 1);
    do_stop(); qd();
    chk("R10 stop clears", addressed, 0);

    // R2 mismatch then matching byte ignored
    s0 = sam_cnt;
    do_start(); send_byte(8'hB6, 0, "R2 mismatch");
    send_byte(8'hB4, 0, "R2 later byte ignored");
    chk("R2 addressed", addressed, 0);
    chk("R2 sam", sam_cnt - s0, 0);
    do_stop();

    // R3 inhibit
    inhibit = 1'b1; s0 = sam_cnt;
    do_start(); send_byte(8'hB4, 0, "R3 inhibit");
    chk("R3 addressed", addressed, 0);
    chk("R3 sam", sam_cnt - s0, 0);
    do_stop(); inhibit = 1'b0;

    // R9 not-acknowledge control
    nak = 1'b1; s0 = sam_cnt;
    do_start(); send_byte(8'hB4, 0, "R9 nack");
    chk("R9 sam", sam_cnt - s0, 1);
    chk("R9 addressed", addressed, 1);
    chk("R9 rw", rw, 0);
    do_stop(); nak = 1'b0;

    // 10-bit mode: address = {2'b10, 8'h5A}
    ten_bit = 1'b1; s0 = sam_cnt;
    do_start(); send_byte(8'hF4, 1, "R4 header ack");
    chk("R4 no sam on header", sam_cnt - s0, 0);
    chk("R4 not yet addressed", addressed, 0);
    send_byte(8'h5A, 1, "R5 low ack");
    chk("R5 sam", sam_cnt - s0, 1);
    chk("R5 addressed", addressed, 1);
    chk("R5 rw", rw, 0);

    // R7 repeated start with read header
    s0 = sam_cnt;
    do_start(); send_byte(8'hF5, 1, "R7 reselect ack");
    chk("R7 sam", sam_cnt - s0, 1);
    chk("R7 rw", rw, 1);
    chk("R7 addressed", addressed, 1);
    do_stop(); qd();
    chk("R10 stop clears 10-bit", addressed, 0);

    // R8 read header after stop
    s0 = sam_cnt;
    do_start(); send_byte(8'hF5, 0, "R8 read header after stop");
    chk("R8 addressed", addressed, 0);
    chk("R8 sam", sam_cnt - s0, 0);
    do_stop();

    // R6 wrong low byte
    s0 = sam_cnt;
    do_start(); send_byte(8'hF4, 1, "R6 header ack");
    send_byte(8'h5B, 0, "R6 low mismatch");
    chk("R6 addressed", addressed, 0);
    chk("R6 sam", sam_cnt - s0, 0);
    do_stop();

    // R4 wrong upper bits and non-prefix byte
    do_start(); send_byte(8'hF2, 0, "R4 upper bits mismatch"); do_stop();
    do_start(); send_byte(8'hB4, 0, "R4 no prefix"); do_stop();
    qd();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule